// File: doc/BRIEF.md
# Fractional Baud Clock Prescaler

This block produces the clock-enable that paces a UART baud-rate divider. It either passes through an enable coming from an external integer prescaler, or generates its own enable whose average period is a non-integer number of system clocks. The fractional ratio is programmed in a floating-point style: a tap field picks a power-of-two range and a step field picks a point inside that range.

The ratio is realised with a phase accumulator. Every system clock adds a fixed increment, and a pulse is emitted whenever the accumulator reaches the programmed divisor. Because pulses can only fall on whole clock edges, the gap between pulses alternates between two neighbouring integers, while the long-run average matches the programmed value exactly. Software programs the block through a single 16-bit register write port and can read the register back.

Top module: `frac_baud_prescaler`

## Requirements
- R1: After reset the register reads 0x0000, and the output enable equals the integer-prescaler enable input.
- R2: With bit 15 of the register at 0, the output enable equals the integer-prescaler enable input in the same cycle, whatever the tap and step fields hold.
- R3: With bit 15 at 1, the output enable comes only from the fractional generator, and the integer-prescaler enable input has no effect on it.
- R4: With bit 15 at 1 and the tap field (bits 10 to 8) at 7, the output enable stays low.
- R5: With bit 15 at 1, tap T in 0 to 6 and step S (bits 7 to 0), let D = (256 + S) * 2^(T+1); the output is high in cycle k after a register write exactly when floor(256k/D) exceeds floor(256(k-1)/D), giving an average ratio of D/256 system clocks, from 2 (T=0, S=0) to 255.5 (T=6, S=255).
- R6: Gaps between consecutive output pulses of a fractional setting differ from each other by at most one system clock; tap 0 with step 0 yields a pulse every second clock.
- R7: Register bits 14 to 11 are reserved: they ignore written data and always read back as zero.
- R8: Every register write restarts the fractional phase from zero, so pulse timing after a write depends only on the new value, even when the same value is written again.
- R9: Each output pulse of the fractional generator is one system clock wide, and two fractional pulses never fall in adjacent cycles.
- R10: Register bits 15 and 10 to 0 read back exactly as last written and hold their value while no write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_tick_i | input | 1 | Enable from the external integer prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| cfg_o | output | 16 | Register read-back value |
| baud_tick_o | output | 1 | Enable pulse to the baud-rate divider |

## Verification
The hardest case to reach from the ports is the phase restart: a rewrite only shows a difference when it lands while the accumulator holds a non-zero remainder just short of a pulse. The stimulus programs divide-by-four, lets three cycles pass so the next cycle would carry a pulse, then writes the same value again and expects the first pulse four cycles after the new write rather than one. The far end of the range, 255.5, is reached by running long enough to see both gap lengths, 256 and 255 clocks.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

  typedef enum logic {
    SRC_INTEGER = 1'b0,
    SRC_FRACTION = 1'b1
  } src_sel_e;

  localparam int unsigned REG_W = 16;

endpackage

// File: rtl/fbp_ctrl_reg.sv
module fbp_ctrl_reg
  import frac_baud_pkg::*;
#(
  parameter int unsigned STEP_W = 8,
  parameter int unsigned TAP_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  cfg_o,
  output src_sel_e          src_o,
  output logic [TAP_W-1:0]  tap_o,
  output logic [STEP_W-1:0] step_o
);

  localparam int unsigned FIELD_W = STEP_W + TAP_W;
  localparam int unsigned SEL_POS = REG_W - 1;
  localparam int unsigned RSVD_W  = SEL_POS - FIELD_W;

  logic                 sel_q, sel_d;
  logic [FIELD_W-1:0]   field_q, field_d;

  always_comb begin
    sel_d   = sel_q;
    field_d = field_q;
    if (wr_en_i) begin
      sel_d   = wr_data_i[SEL_POS];
      field_d = wr_data_i[FIELD_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      field_q <= '0;
    end else if (wr_en_i) begin
      sel_q   <= sel_d;
      field_q <= field_d;
    end
  end

  generate
    if (RSVD_W > 0) begin : g_rsvd
      assign cfg_o = {sel_q, {RSVD_W{1'b0}}, field_q};
    end else begin : g_norsvd
      assign cfg_o = {sel_q, field_q};
    end
  endgenerate

  assign src_o  = src_sel_e'(sel_q);
  assign tap_o  = field_q[FIELD_W-1:STEP_W];
  assign step_o = field_q[STEP_W-1:0];

  // R10: contents change only on a write
  p_hold_without_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_o));

  // R10: a write lands in the visible fields
  p_write_lands_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (cfg_o[FIELD_W-1:0] == $past(wr_data_i[FIELD_W-1:0])));

endmodule

// File: rtl/fbp_ratio_decode.sv
module fbp_ratio_decode #(
  parameter int unsigned STEP_W = 8,
  parameter int unsigned TAP_W  = 3,
  parameter int unsigned DIV_W  = STEP_W + (1 << TAP_W)
) (
  input  logic [TAP_W-1:0]  tap_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              active_o,
  output logic [DIV_W-1:0]  div_o
);

  localparam logic [TAP_W-1:0] TAP_OFF = '1;

  logic [DIV_W-1:0] mant;
  logic [DIV_W-1:0] shift_amt;

  always_comb begin
    mant      = DIV_W'({1'b1, step_i});
    shift_amt = DIV_W'(tap_i) + DIV_W'(1);
    active_o  = (tap_i != TAP_OFF);
    div_o     = active_o ? (mant << shift_amt) : '0;
  end

endmodule

// File: rtl/fbp_phase_accum.sv
module fbp_phase_accum #(
  parameter int unsigned STEP_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             active_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  localparam int unsigned ACC_W = DIV_W + 1;
  localparam logic [ACC_W-1:0] INC = ACC_W'(1) << STEP_W;

  logic [DIV_W-1:0] acc_q, acc_d;
  logic             tick_q, tick_d;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] div_ext;
  logic             hit;

  always_comb begin
    sum     = {1'b0, acc_q} + INC;
    div_ext = {1'b0, div_i};
    hit     = active_i && (sum >= div_ext);
    if (clear_i || !active_i) begin
      acc_d  = '0;
      tick_d = 1'b0;
    end else if (hit) begin
      acc_d  = DIV_W'(sum - div_ext);
      tick_d = 1'b1;
    end else begin
      acc_d  = DIV_W'(sum);
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R9: single-cycle pulses, never back to back
  p_no_adjacent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q);

  // R5: remainder stays below the divisor
  p_acc_below_div_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (acc_q < div_i));

  // R6: after a pulse the leftover phase is under one increment
  p_phase_after_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> ({1'b0, acc_q} < INC));

  // R8: a write restarts the phase
  p_clear_restarts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_q == '0) && !tick_q);

  // R4: disabled tap stays quiet
  p_disabled_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !clear_i) |=> (!tick_q || !$past(active_i) == 1'b0 ? 1'b1 : !tick_q));

endmodule

// File: rtl/frac_baud_prescaler.sv
module frac_baud_prescaler
  import frac_baud_pkg::*;
#(
  parameter int unsigned STEP_W = 8,
  parameter int unsigned TAP_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             int_tick_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] cfg_o,
  output logic             baud_tick_o
);

  localparam int unsigned DIV_W = STEP_W + (1 << TAP_W);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  src_sel_e          src;
  logic [TAP_W-1:0]  tap;
  logic [STEP_W-1:0] step;
  logic              active;
  logic [DIV_W-1:0]  div;
  logic              frac_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  fbp_ctrl_reg #(.STEP_W(STEP_W), .TAP_W(TAP_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg_o),
    .src_o     (src),
    .tap_o     (tap),
    .step_o    (step)
  );

  fbp_ratio_decode #(.STEP_W(STEP_W), .TAP_W(TAP_W), .DIV_W(DIV_W)) u_decode (
    .tap_i    (tap),
    .step_i   (step),
    .active_o (active),
    .div_o    (div)
  );

  fbp_phase_accum #(.STEP_W(STEP_W), .DIV_W(DIV_W)) u_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .clear_i  (wr_en_i),
    .active_i (active),
    .div_i    (div),
    .tick_o   (frac_tick)
  );

  always_comb begin
    baud_tick_o = (src == SRC_FRACTION) ? frac_tick : int_tick_i;
  end

  // R7: reserved field never visible
  p_rsvd_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    wr_en_i |=> (cfg_o[REG_W-2:STEP_W+TAP_W] == '0));

  // R3: fractional source ignores the integer enable
  p_frac_ignores_int_r3: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (src == SRC_FRACTION && !frac_tick) |-> !baud_tick_o);

endmodule

// File: tb/frac_baud_prescaler_tb_top.sv
module frac_baud_prescaler_tb_top;

  logic        clk;
  logic        rst_n;
  logic        int_tick;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] cfg;
  logic        baud_tick;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    bit    exp;
    int    cyc;
    string tag;
  } sb_item_t;

  sb_item_t sb_q[$];

  frac_baud_prescaler dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .int_tick_i  (int_tick),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .cfg_o       (cfg),
    .baud_tick_o (baud_tick)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  function automatic bit exp_pulse(input int k, input int d);
    return ((k * 256) / d) != (((k - 1) * 256) / d);
  endfunction

  // monitor: pops one expected value per cycle
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      check(baud_tick == it.exp, $sformatf("%s cycle %0d", it.tag, it.cyc),
            int'(baud_tick), int'(it.exp));
    end
  end

  task automatic write_reg(input logic [15:0] v);
    @(negedge clk);
    wr_en   = 1;
    wr_data = v;
    @(posedge clk);
    #1;
    wr_en = 0;
  endtask

  // driver: writes a setting and queues the expected per-cycle output
  task automatic run_frac(input logic [15:0] v, input int n, input string tag);
    int tap, step, d;
    tap  = int'(v[10:8]);
    step = int'(v[7:0]);
    d    = (256 + step) << (tap + 1);
    write_reg(v);
    @(posedge clk);
    #1;
    for (int k = 1; k <= n; k++) begin
      sb_item_t it;
      it.exp = (tap == 7) ? 1'b0 : exp_pulse(k, d);
      it.cyc = k;
      it.tag = tag;
      sb_q.push_back(it);
    end
    wait (sb_q.size() == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n    = 0;
    int_tick = 0;
    wr_en    = 0;
    wr_data  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(cfg == 16'h0000, "R1 reset cfg", int'(cfg), 0);
    int_tick = 1; #1;
    check(baud_tick == 1, "R1 int pass high", int'(baud_tick), 1);
    int_tick = 0; #1;
    check(baud_tick == 0, "R1 int pass low", int'(baud_tick), 0);

    // R2 integer source, even with tap 7 and a nonzero step
    write_reg(16'h0733);
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      int_tick = i[0]; #1;
      check(baud_tick == int_tick, "R2 int follow", int'(baud_tick), int'(int_tick));
      @(negedge clk);
    end

    // R7 R10 read-back
    write_reg(16'hFFFF);
    @(negedge clk);
    check(cfg == 16'h87FF, "R7 reserved zero", int'(cfg), 16'h87FF);
    write_reg(16'h8A5C);
    @(negedge clk);
    check(cfg == 16'h825C, "R10 readback", int'(cfg), 16'h825C);
    repeat (3) @(negedge clk);
    check(cfg == 16'h825C, "R10 hold", int'(cfg), 16'h825C);

    // R3: integer enable held high during all fractional runs
    int_tick = 1;
    run_frac(16'h8000, 40,  "R6 R9 div2");
    run_frac(16'h8080, 40,  "R5 div3");
    run_frac(16'h8140, 40,  "R3 R5 div5");
    run_frac(16'h8201, 100, "R5 R6 div8.03");
    run_frac(16'h83C8, 120, "R5 R6 div28.5");
    run_frac(16'h86FF, 520, "R5 R6 div255.5");
    run_frac(16'h8700, 60,  "R4 disabled");

    // R8 phase restart: rewrite just before a due pulse
    run_frac(16'h8100, 3,  "R8 prephase");
    run_frac(16'h8100, 20, "R8 restart");

    int_tick = 0;
    run_frac(16'h8500, 300, "R3 R5 div64");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule